// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block runs on the host side of a three-wire link to a 12-bit serial analog-to-digital converter. It drives an active-low chip select, drives a data clock derived from the system clock, and reads a serial data line. Raising the chip select powers the converter down, so the line is low only while a transfer is running.

A start request in the idle state begins a frame. The chip select falls, the controller waits one half clock period and then issues a fixed number of data-clock pulses. It samples the data line on each falling edge of the data clock. It throws away the samples from the lead-in pulses and the null bit, and shifts the next 12 samples into a register, most significant bit first. After the low phase of the last pulse the chip select rises. In that same cycle the new word appears on the result port with a one-cycle valid strobe. The converter must then stay powered down for a minimum number of cycles before the next start can be taken.

The state machine has six states. IDLE (chip select high, accepts a start) goes to SETUP on a start. SETUP (chip select low, clock low, one half period) goes to HIGH. HIGH (clock high, one half period) goes to LOW. At that transition the data line is sampled. LOW (clock low, one half period) goes back to HIGH while pulses remain, or on to DONE after the last one. DONE (one cycle, valid strobe, chip select high) goes to RECOVER. RECOVER (RECOVER_CYC cycles, starts ignored) goes back to IDLE.

Top module: `adc_rdout_ctrl`

## Requirements
- R1: Outside SETUP, HIGH and LOW, cs_n_o is 1 and sclk_o is 0.
- R2: A start_i seen high at a clock edge while in IDLE drives cs_n_o low from the next cycle on. cs_n_o never falls without such a start.
- R3: After cs_n_o falls, sclk_o stays low for HALF_DIV cycles. It then gives PULSES pulses, each HALF_DIV cycles high followed by HALF_DIV cycles low, and cs_n_o rises in the cycle right after the last low phase.
- R4: sdata_i is sampled at the system-clock edge where sclk_o goes from 1 to 0, taking the value held during the last high cycle.
- R5: The samples from the first LEAD_CLKS pulses and the NULL_BITS pulses after them have no effect on result_o.
- R6: The next DATA_W samples form result_o. The first of them lands in bit DATA_W-1 and the last in bit 0.
- R7: valid_o is high for exactly one cycle per frame, the first cycle with cs_n_o high again. result_o takes its new value in that cycle and holds it until the next valid_o.
- R8: busy_o is high from the cycle after a start is accepted up to and including the valid_o cycle, and low otherwise.
- R9: start_i has no effect while busy_o is high.
- R10: start_i has no effect during the RECOVER_CYC cycles after valid_o, so cs_n_o stays high for at least RECOVER_CYC+2 cycles between frames.
- R11: While rst is high, the block returns at each clock edge to IDLE with cs_n_o 1, sclk_o 0, busy_o 0, valid_o 0 and result_o 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to read one conversion |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip select, active low; high powers the converter down |
| sclk_o | output | 1 | Data clock to the converter |
| busy_o | output | 1 | Frame in progress |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| result_o | output | DATA_W | Last captured conversion word |

## Verification
The assertions check the following on every cycle: the clock stays quiet while the chip select is high, the chip select falls only after a start, busy stays high until the strobe, the strobe lasts one cycle at chip-select rise, the result is stable between strobes, the power-down gap is kept, and reset clears everything. Only the bench scenarios can show that the right data bits are taken on falling edges, that lead-in and null samples are dropped, that the pulse count and phase lengths are exact, and that starts during a frame or during recovery are ignored. The bench shows this by comparing every output against a behavioural model on every cycle while it drives chosen bit streams.

// File: rtl/adc_rdout_pkg.sv
package adc_rdout_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_DONE,
        ST_RECOVER
    } rd_state_e;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/adc_interval_timer.sv
module adc_interval_timer #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic expire
);
    import adc_rdout_pkg::*;

    generate
        if (LEN <= 1) begin : g_single
            // every cycle ends an interval
            assign expire = 1'b1;
        end else begin : g_count
            localparam int unsigned CW = cnt_width(LEN);
            localparam logic [CW-1:0] LAST = CW'(LEN - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign expire = (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/adc_pulse_counter.sv
module adc_pulse_counter #(
    parameter int unsigned PULSES = 15,
    parameter int unsigned SKIP   = 3,
    parameter int unsigned DATA_W = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic fall,
    output logic capture,
    output logic all_done
);
    import adc_rdout_pkg::*;

    localparam int unsigned CW = cnt_width(PULSES + 1);
    localparam logic [CW-1:0] FIRST_DATA = CW'(SKIP);
    localparam logic [CW-1:0] END_DATA   = CW'(SKIP + DATA_W);
    localparam logic [CW-1:0] TOTAL      = CW'(PULSES);

    generate
        if (PULSES < SKIP + DATA_W) begin : g_bad_cfg
            $error("PULSES too small for lead-in, null and data bits");
        end
    endgenerate

    logic [CW-1:0] done_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            done_q <= '0;
        end else if (fall && done_q != TOTAL) begin
            done_q <= done_q + 1'b1;
        end
    end

    // done_q is the 0-based index of the pulse now ending
    assign capture  = fall && (done_q >= FIRST_DATA) && (done_q < END_DATA);
    assign all_done = (done_q == TOTAL);

endmodule

// File: rtl/adc_capture_sreg.sv
module adc_capture_sreg #(
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              shift,
    input  logic              bit_in,
    input  logic              publish,
    output logic [DATA_W-1:0] word_o
);
    logic [DATA_W-1:0] shreg_q;
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            shreg_q <= '0;
        end else if (shift) begin
            shreg_q <= {shreg_q[DATA_W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (publish) begin
            word_q <= shreg_q;
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/adc_rdout_ctrl.sv
module adc_rdout_ctrl #(
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned LEAD_CLKS   = 2,
    parameter int unsigned NULL_BITS   = 1,
    parameter int unsigned PULSES      = LEAD_CLKS + NULL_BITS + DATA_W,
    parameter int unsigned HALF_DIV    = 4,
    parameter int unsigned RECOVER_CYC = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              sdata_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              busy_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] result_o
);
    import adc_rdout_pkg::*;

    localparam int unsigned SKIP = LEAD_CLKS + NULL_BITS;

    rd_state_e state_q, state_d;

    logic phase_exp;
    logic gap_exp;
    logic fall_evt;
    logic cap_en;
    logic pulses_done;
    logic frame_begin;
    logic publish;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i)   state_d = ST_SETUP;
            ST_SETUP:   if (phase_exp) state_d = ST_HIGH;
            ST_HIGH:    if (phase_exp) state_d = ST_LOW;
            ST_LOW:     if (phase_exp) state_d = pulses_done ? ST_DONE : ST_HIGH;
            ST_DONE:                   state_d = ST_RECOVER;
            ST_RECOVER: if (gap_exp)   state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs from state
    always_comb begin
        cs_n_o  = 1'b1;
        sclk_o  = 1'b0;
        busy_o  = 1'b0;
        valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SETUP: begin
                cs_n_o = 1'b0;
                busy_o = 1'b1;
            end
            ST_HIGH: begin
                cs_n_o = 1'b0;
                sclk_o = 1'b1;
                busy_o = 1'b1;
            end
            ST_LOW: begin
                cs_n_o = 1'b0;
                busy_o = 1'b1;
            end
            ST_DONE: begin
                busy_o  = 1'b1;
                valid_o = 1'b1;
            end
            ST_RECOVER: ;
            default: ;
        endcase
    end

    assign frame_begin = (state_q == ST_IDLE) && start_i;
    assign fall_evt    = (state_q == ST_HIGH) && phase_exp;
    assign publish     = (state_q == ST_LOW) && phase_exp && pulses_done;

    adc_interval_timer #(
        .LEN(HALF_DIV)
    ) u_phase_tmr (
        .clk   (clk),
        .rst   (rst),
        .clear (state_d != state_q),
        .expire(phase_exp)
    );

    adc_interval_timer #(
        .LEN(RECOVER_CYC)
    ) u_gap_tmr (
        .clk   (clk),
        .rst   (rst),
        .clear (state_q != ST_RECOVER),
        .expire(gap_exp)
    );

    adc_pulse_counter #(
        .PULSES(PULSES),
        .SKIP  (SKIP),
        .DATA_W(DATA_W)
    ) u_pulses (
        .clk     (clk),
        .rst     (rst),
        .clear   (frame_begin),
        .fall    (fall_evt),
        .capture (cap_en),
        .all_done(pulses_done)
    );

    adc_capture_sreg #(
        .DATA_W(DATA_W)
    ) u_capture (
        .clk    (clk),
        .rst    (rst),
        .clear  (frame_begin),
        .shift  (cap_en),
        .bit_in (sdata_i),
        .publish(publish),
        .word_o (result_o)
    );

endmodule

// File: rtl/adc_rdout_checker.sv
module adc_rdout_checker #(
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned RECOVER_CYC = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              cs_n_o,
    input logic              sclk_o,
    input logic              busy_o,
    input logic              valid_o,
    input logic [DATA_W-1:0] result_o
);
    localparam int unsigned GAP_LIM = RECOVER_CYC + 1;
    localparam int unsigned GW = $clog2(GAP_LIM + 1);

    logic [GW-1:0] since_valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_valid_q <= GW'(GAP_LIM);
        end else if (valid_o) begin
            since_valid_q <= '0;
        end else if (since_valid_q != GW'(GAP_LIM)) begin
            since_valid_q <= since_valid_q + 1'b1;
        end
    end

    p_idle_clock_low_r1: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sclk_o);

    p_cs_fall_on_start_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> $past(start_i) && !$past(busy_o));

    p_clock_framed_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_o) |-> !cs_n_o && busy_o);

    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    p_valid_cs_high_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> cs_n_o);

    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(result_o));

    p_busy_until_valid_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !valid_o) |=> busy_o);

    p_busy_covers_frame_r8: assert property (@(posedge clk) disable iff (rst)
        !cs_n_o |-> busy_o);

    p_no_restart_busy_r9: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> !$fell(cs_n_o));

    p_gap_kept_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> (since_valid_q == GW'(GAP_LIM)));

    p_reset_state_r11: assert property (@(posedge clk)
        rst |=> (cs_n_o && !sclk_o && !busy_o && !valid_o && result_o == '0));

endmodule

bind adc_rdout_ctrl adc_rdout_checker #(
    .DATA_W     (DATA_W),
    .RECOVER_CYC(RECOVER_CYC)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .busy_o  (busy_o),
    .valid_o (valid_o),
    .result_o(result_o)
);

// File: tb/tb_adc_rdout_ctrl.sv
module tb_adc_rdout_ctrl;

    localparam int W    = 12;
    localparam int LEAD = 2;
    localparam int NUL  = 1;
    localparam int SKIP = LEAD + NUL;
    localparam int P    = SKIP + W;
    localparam int H    = 3;
    localparam int G    = 5;
    localparam int F    = H + 2 * H * P;   // frame index of the valid cycle

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         sdata_i = 1'b0;
    logic         cs_n_o, sclk_o, busy_o, valid_o;
    logic [W-1:0] result_o;

    int vectors = 0;
    int fails   = 0;
    bit armed    = 0;
    bit finished = 0;

    // behavioural model state
    int           idx = -1;
    logic [W-1:0] nx_word = '0, cur_word = '0, exp_result = '0;
    logic [2:0]   nx_junk = '0, cur_junk = '0;

    always #4 clk = ~clk;

    adc_rdout_ctrl #(
        .DATA_W(W), .LEAD_CLKS(LEAD), .NULL_BITS(NUL), .PULSES(P),
        .HALF_DIV(H), .RECOVER_CYC(G)
    ) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .sdata_i(sdata_i),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .busy_o(busy_o),
        .valid_o(valid_o), .result_o(result_o)
    );

    // model update: starts count only in idle (R9, R10)
    always @(posedge clk) begin
        if (rst) begin
            armed      <= 1'b1;
            idx        <= -1;
            exp_result <= '0;
        end else begin
            if (idx == -1) begin
                if (start_i) begin
                    idx      <= 0;
                    cur_word <= nx_word;
                    cur_junk <= nx_junk;
                end
            end else if (idx == F + G) begin
                idx <= -1;
            end else begin
                idx <= idx + 1;
            end
            if (idx == F - 1) exp_result <= cur_word;
        end
    end

    // compare every cycle, then drive the serial data for this cycle
    always @(negedge clk) begin
        logic e_cs, e_sclk, e_busy, e_valid;
        int   k;
        e_cs = 1'b1; e_sclk = 1'b0; e_busy = 1'b0; e_valid = 1'b0;
        if (idx >= 0 && idx < F) begin
            e_cs   = 1'b0;
            e_busy = 1'b1;
            if (idx >= H) e_sclk = (((idx - H) % (2 * H)) < H);
        end else if (idx == F) begin
            e_busy  = 1'b1;
            e_valid = 1'b1;
        end
        if (armed && !finished) begin
            vectors++;
            if (cs_n_o !== e_cs) begin
                fails++;
                $display("FAIL %s cs_n_o got %0b exp %0b (idx %0d)", rst ? "R11" : "R1/R2/R10", cs_n_o, e_cs, idx);
            end
            if (sclk_o !== e_sclk) begin
                fails++;
                $display("FAIL %s sclk_o got %0b exp %0b (idx %0d)", rst ? "R11" : "R3", sclk_o, e_sclk, idx);
            end
            if (busy_o !== e_busy) begin
                fails++;
                $display("FAIL %s busy_o got %0b exp %0b (idx %0d)", rst ? "R11" : "R8/R9", busy_o, e_busy, idx);
            end
            if (valid_o !== e_valid) begin
                fails++;
                $display("FAIL %s valid_o got %0b exp %0b (idx %0d)", rst ? "R11" : "R7", valid_o, e_valid, idx);
            end
            if (result_o !== exp_result) begin
                fails++;
                $display("FAIL %s result_o got %h exp %h (idx %0d)", rst ? "R11" : "R4/R5/R6", result_o, exp_result, idx);
            end
        end
        // pulse k holds its bit through its low and high phases; R4 sampling
        // on the rising edge would pick pulse k-1 and miscompare
        k = (idx >= H) ? (idx - H) / (2 * H) : -1;
        if (idx >= H && k < P) begin
            if (k < SKIP) sdata_i = cur_junk[k];            // R5 discarded
            else          sdata_i = cur_word[W - 1 - (k - SKIP)]; // R6 MSB first
        end else begin
            sdata_i = ~sdata_i;
        end
    end

    task automatic pulse_start(input logic [W-1:0] w, input logic [2:0] j);
        @(negedge clk);
        nx_word = w;
        nx_junk = j;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (idx != -1) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R3 R4 R5 R6 R7: assorted words, junk opposite to data
        pulse_start(12'hA5C, 3'b101); wait_idle();
        pulse_start(12'h000, 3'b111); wait_idle();
        pulse_start(12'hFFF, 3'b000); wait_idle();
        pulse_start(12'h801, 3'b010); wait_idle();
        pulse_start(12'h001, 3'b110); wait_idle();

        // R9: start while busy is ignored
        pulse_start(12'h3C6, 3'b011);
        repeat (20) @(negedge clk);
        nx_word = 12'h7E1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();

        // R10: starts during recovery are ignored
        pulse_start(12'h5A5, 3'b100);
        while (idx != F + 2) @(negedge clk);
        pulse_start(12'h0F0, 3'b001);
        wait_idle();

        // R2 R10: start held high back to back
        nx_word = 12'h9B4;
        nx_junk = 3'b111;
        start_i = 1'b1;
        repeat (2 * (F + G + 2) + 5) @(negedge clk);
        start_i = 1'b0;
        wait_idle();

        // R11: reset in the middle of a frame
        pulse_start(12'hC3A, 3'b000);
        repeat (40) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        pulse_start(12'h456, 3'b101); wait_idle();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog expired got running exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule